// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Controller

This block places the bytes coming out of a serial receiver into data buffers in memory. The buffers are described by a ring of descriptors kept in a small descriptor RAM. Before it accepts any data, the block reads the descriptor at the current ring position. If that descriptor is marked empty, incoming bytes go to consecutive byte addresses starting at the descriptor's buffer pointer. The buffer is closed when the programmed maximum length is reached or when the receiver marks a byte as the end of the frame.

On close, one descriptor write stores the byte count together with the updated status. The controller then raises an event if the descriptor asks for one and moves to the next ring slot. A slot marked last sends it back to the ring base, so the ring length is set only by where that mark sits. In loop mode the empty mark stays set, so the same buffer can be filled again on the next pass. A receive error always hands the buffer to the host, whatever the loop setting. If data arrives while the current descriptor is still owned by the host, the bytes are dropped, a busy event is raised and the same slot is read again.

The descriptor word is `{pointer[AW-1:0], count[15:0], status[15:0]}` and is held in one RAM word per slot at `ring_base + slot`. The descriptor RAM returns read data one cycle after `desc_rd`. The byte source leaves enough idle cycles after a closing byte or a dropped byte that the next byte is sampled no earlier than the fifth rising edge after it (see R11).

Top module: `rxbd_ring_ctrl`

## Requirements
- R1: While reset is asserted, `mem_we`, `desc_wr`, `desc_rd`, `evt_rx`, `evt_busy` and `irq` are 0. After reset is released, the first rising edge raises `desc_rd` with `desc_addr` equal to `ring_base`.
- R2: Status bits are: bit 0 empty, bit 1 last, bit 2 notify, bit 3 loop, bit 4 overrun. Bits 31:16 hold the count and bits 32 and up hold the buffer pointer, which must be even. The k-th byte accepted into a buffer (k from 0) is written at `pointer + k`, with `mem_we` high in the cycle after the byte is sampled.
- R3: When the number of bytes in the current buffer reaches `max_len`, the buffer is closed and the count field written back equals `max_len`.
- R4: A byte with `rx_last` set closes the buffer, and the written count equals the number of bytes in that buffer. A close never writes a count of zero.
- R5: A close produces exactly one descriptor write, in the second cycle after the closing byte, to the slot's own address. The write keeps the pointer and the last, notify and loop bits unchanged, and it never coincides with a descriptor read.
- R6: Without an error, the written-back empty bit is 0 for a normal descriptor and stays 1 for a loop descriptor.
- R7: If any byte of the buffer carried `rx_ovr`, the written-back overrun bit is 1 and the empty bit is 0, whatever the loop bit says. Otherwise the overrun bit is 0.
- R8: After a close, the next descriptor read is at `ring_base` if the closed slot had the last bit, and at the following slot otherwise.
- R9: `evt_rx` is a one-cycle pulse aligned with the write-back when the closed descriptor has the notify bit set. `irq` pulses in that same cycle only if `irq_mask[0]` is 1.
- R10: A byte that arrives while the loaded descriptor's empty bit is 0 is not stored. In the next cycle `evt_busy` pulses, and so does `irq` if `irq_mask[1]` is 1. The same slot is then read again without advancing.
- R11: After a close, the descriptor read is issued in the third cycle after the closing byte. A byte sampled on the fifth rising edge after the closing byte is accepted into the next buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | DA_W | Descriptor RAM address of ring slot 0 |
| max_len | input | 16 | Maximum number of bytes per buffer |
| irq_mask | input | 2 | Bit 0 enables irq for receive events, bit 1 for busy events |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_ovr | input | 1 | Receiver overran while collecting this byte |
| mem_we | output | 1 | Data memory byte write strobe |
| mem_addr | output | AW | Data memory byte address |
| mem_wdata | output | 8 | Data memory write byte |
| desc_rd | output | 1 | Descriptor read request |
| desc_wr | output | 1 | Descriptor write strobe |
| desc_addr | output | DA_W | Descriptor RAM address |
| desc_wdata | output | 32+AW | Descriptor write-back word |
| desc_rdata | input | 32+AW | Descriptor read word, valid one cycle after desc_rd |
| evt_rx | output | 1 | Buffer closed on a notifying descriptor |
| evt_busy | output | 1 | Byte dropped because no empty buffer was available |
| irq | output | 1 | Masked event pulse |

## Verification
A wrong byte counter or pointer register shows up at once as a wrong `mem_addr` on the very next stored byte. A wrong close decision shows up two cycles after the closing byte, as a missing write-back or a wrong count. A wrong ring index or slot register is visible at the read that follows each close or dropped byte, one cycle after the write-back. Stale ownership state shows up on the next byte, either as a store into a buffer that is still owned by the host or as a busy pulse when the slot was free. Because the descriptor RAM is modelled at the ports, a bad status merge is also caught when a loop buffer is reused, or not reused, on the following pass.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

   // status field bit positions inside the descriptor word
   localparam int ST_EMPTY  = 0;
   localparam int ST_LAST   = 1;
   localparam int ST_NOTIFY = 2;
   localparam int ST_LOOP   = 3;
   localparam int ST_OVR    = 4;

   localparam int STAT_W = 16;
   localparam int CNT_W  = 16;

   typedef enum logic [2:0] {
      S_FETCH,
      S_WAIT,
      S_LOAD,
      S_READY,
      S_CLOSE
   } ctl_state_t;

endpackage

// File: rtl/rxbd_ring.sv
module rxbd_ring #(
   parameter int DA_W     = 8,
   parameter int MAX_DESC = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DA_W-1:0] base,
   input  logic            advance,
   input  logic            last,
   output logic [DA_W-1:0] slot_addr
);
   localparam int IDX_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(MAX_DESC - 1);

   logic [IDX_W-1:0] idx;

   generate
      if (MAX_DESC < 1) begin : g_bad_depth
         $error("rxbd_ring: MAX_DESC must be at least 1");
      end
      if (IDX_W > DA_W) begin : g_bad_width
         $error("rxbd_ring: ring index wider than descriptor address");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (advance) begin
         if (last || idx == IDX_TOP) idx <= '0;
         else                       idx <= idx + 1'b1;
      end
   end

   assign slot_addr = base + DA_W'(idx);

   assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && last) |=> (slot_addr == base));

endmodule

// File: rtl/rxbd_fill.sv
module rxbd_fill #(
   parameter int AW    = 12,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    ptr_in,
   input  logic             take,
   input  logic [7:0]       din,
   input  logic             err,
   input  logic [CNT_W-1:0] max_len,
   output logic [AW-1:0]    buf_ptr,
   output logic [CNT_W-1:0] count,
   output logic             ovr,
   output logic             full_hit,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [7:0]       mem_wdata
);
   logic [CNT_W-1:0] count_inc;
   logic [AW-1:0]    off;

   assign count_inc = count + 1'b1;
   // max_len of 0 behaves as 1 so a buffer can never run away
   assign full_hit  = (count_inc >= max_len);

   generate
      if (AW <= CNT_W) begin : g_off_narrow
         assign off = count[AW-1:0];
      end else begin : g_off_wide
         assign off = {{(AW-CNT_W){1'b0}}, count};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_ptr   <= '0;
         count     <= '0;
         ovr       <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= take;
         if (load) begin
            buf_ptr <= ptr_in;
            count   <= '0;
            ovr     <= 1'b0;
         end else if (take) begin
            mem_addr  <= buf_ptr + off;
            mem_wdata <= din;
            count     <= count_inc;
            ovr       <= ovr | err;
         end
      end
   end

   logic [AW-1:0] win_off;
   assign win_off = mem_addr - buf_ptr;

   assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && max_len != '0) |->
         ({{CNT_W{1'b0}}, win_off} < {{AW{1'b0}}, max_len}));

endmodule

// File: rtl/rxbd_status.sv
module rxbd_status
   import rxbd_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      close_go,
   input  logic                      busy_go,
   input  logic [STAT_W-1:0]         cur_stat,
   input  logic [AW-1:0]             buf_ptr,
   input  logic [CNT_W-1:0]          count,
   input  logic                      ovr,
   input  logic [1:0]                irq_mask,
   output logic                      desc_wr,
   output logic [STAT_W+CNT_W+AW-1:0] desc_wdata,
   output logic                      evt_rx,
   output logic                      evt_busy,
   output logic                      irq
);
   logic [STAT_W-1:0] wb_stat;
   logic              rx_hit;

   always_comb begin
      wb_stat           = cur_stat;
      wb_stat[ST_OVR]   = ovr;
      wb_stat[ST_EMPTY] = cur_stat[ST_LOOP] & ~ovr;
   end

   assign rx_hit = close_go & cur_stat[ST_NOTIFY];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         desc_wr    <= 1'b0;
         desc_wdata <= '0;
         evt_rx     <= 1'b0;
         evt_busy   <= 1'b0;
         irq        <= 1'b0;
      end else begin
         desc_wr  <= close_go;
         evt_rx   <= rx_hit;
         evt_busy <= busy_go;
         irq      <= (rx_hit & irq_mask[0]) | (busy_go & irq_mask[1]);
         if (close_go) desc_wdata <= {buf_ptr, count, wb_stat};
      end
   end

   assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      desc_wr |-> (desc_wdata[STAT_W +: CNT_W] != '0));

   assert_rx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_rx |=> !evt_rx);

   assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (evt_rx || evt_busy));

   assert_ovr_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_wr && desc_wdata[ST_OVR]) |-> !desc_wdata[ST_EMPTY]);

endmodule

// File: rtl/rxbd_ring_ctrl.sv
module rxbd_ring_ctrl
   import rxbd_pkg::*;
#(
   parameter int AW       = 12,
   parameter int DA_W     = 8,
   parameter int MAX_DESC = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [DA_W-1:0]               ring_base,
   input  logic [CNT_W-1:0]              max_len,
   input  logic [1:0]                    irq_mask,
   input  logic                          rx_valid,
   input  logic [7:0]                    rx_byte,
   input  logic                          rx_last,
   input  logic                          rx_ovr,
   output logic                          mem_we,
   output logic [AW-1:0]                 mem_addr,
   output logic [7:0]                    mem_wdata,
   output logic                          desc_rd,
   output logic                          desc_wr,
   output logic [DA_W-1:0]               desc_addr,
   output logic [STAT_W+CNT_W+AW-1:0]    desc_wdata,
   input  logic [STAT_W+CNT_W+AW-1:0]    desc_rdata,
   output logic                          evt_rx,
   output logic                          evt_busy,
   output logic                          irq
);
   localparam int PTR_LSB = STAT_W + CNT_W;

   generate
      if (AW < 4) begin : g_bad_aw
         $error("rxbd_ring_ctrl: AW must be at least 4");
      end
      if (DA_W < 1) begin : g_bad_da
         $error("rxbd_ring_ctrl: DA_W must be at least 1");
      end
   endgenerate

   ctl_state_t        state;
   logic [STAT_W-1:0] cur_stat;
   logic [DA_W-1:0]   slot_addr;
   logic [AW-1:0]     buf_ptr;
   logic [CNT_W-1:0]  count;
   logic              ovr;
   logic              full_hit;
   logic              take, busy_go, close_go, load;
   logic              unused_rd_cnt;

   assign unused_rd_cnt = ^desc_rdata[STAT_W +: CNT_W];

   assign load     = (state == S_LOAD);
   assign take     = (state == S_READY) && rx_valid && cur_stat[ST_EMPTY];
   assign busy_go  = (state == S_READY) && rx_valid && !cur_stat[ST_EMPTY];
   assign close_go = (state == S_CLOSE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_FETCH;
         desc_rd   <= 1'b0;
         desc_addr <= '0;
         cur_stat  <= '0;
      end else begin
         desc_rd <= 1'b0;
         case (state)
            S_FETCH: begin
               desc_rd   <= 1'b1;
               desc_addr <= slot_addr;
               state     <= S_WAIT;
            end
            S_WAIT:  state <= S_LOAD;
            S_LOAD: begin
               cur_stat <= desc_rdata[STAT_W-1:0];
               state    <= S_READY;
            end
            S_READY: begin
               if (busy_go)                            state <= S_FETCH;
               else if (take && (rx_last || full_hit)) state <= S_CLOSE;
            end
            S_CLOSE: state <= S_FETCH;
            default: state <= S_FETCH;
         endcase
      end
   end

   rxbd_ring #(
      .DA_W     (DA_W),
      .MAX_DESC (MAX_DESC)
   ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .base      (ring_base),
      .advance   (close_go),
      .last      (cur_stat[ST_LAST]),
      .slot_addr (slot_addr)
   );

   rxbd_fill #(
      .AW    (AW),
      .CNT_W (CNT_W)
   ) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .ptr_in    (desc_rdata[PTR_LSB +: AW]),
      .take      (take),
      .din       (rx_byte),
      .err       (rx_ovr),
      .max_len   (max_len),
      .buf_ptr   (buf_ptr),
      .count     (count),
      .ovr       (ovr),
      .full_hit  (full_hit),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   rxbd_status #(
      .AW (AW)
   ) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .close_go   (close_go),
      .busy_go    (busy_go),
      .cur_stat   (cur_stat),
      .buf_ptr    (buf_ptr),
      .count      (count),
      .ovr        (ovr),
      .irq_mask   (irq_mask),
      .desc_wr    (desc_wr),
      .desc_wdata (desc_wdata),
      .evt_rx     (evt_rx),
      .evt_busy   (evt_busy),
      .irq        (irq)
   );

   assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_go |=> (!mem_we && evt_busy && state == S_FETCH));

   assert_rw_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(desc_rd && desc_wr));

   assert_even_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && desc_rdata[ST_EMPTY]) |-> !desc_rdata[PTR_LSB]);

endmodule

// File: tb/rxbd_ring_ctrl_test.sv
module rxbd_ring_ctrl_test;
   localparam int AW    = 12;
   localparam int DA_W  = 8;
   localparam int DW    = 32 + AW;
   localparam int NDESC = 4;
   localparam logic [DA_W-1:0] BASE = 8'd8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [DA_W-1:0] ring_base = BASE;
   logic [15:0]     max_len = 16'd4;
   logic [1:0]      irq_mask = 2'b11;
   logic            rx_valid = 1'b0, rx_last = 1'b0, rx_ovr = 1'b0;
   logic [7:0]      rx_byte = 8'h00;
   logic            mem_we, desc_rd, desc_wr, evt_rx, evt_busy, irq;
   logic [AW-1:0]   mem_addr;
   logic [7:0]      mem_wdata;
   logic [DA_W-1:0] desc_addr;
   logic [DW-1:0]   desc_wdata;
   logic [DW-1:0]   desc_rdata = '0;

   rxbd_ring_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .max_len(max_len),
      .irq_mask(irq_mask), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_last(rx_last), .rx_ovr(rx_ovr), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .desc_rd(desc_rd), .desc_wr(desc_wr),
      .desc_addr(desc_addr), .desc_wdata(desc_wdata), .desc_rdata(desc_rdata),
      .evt_rx(evt_rx), .evt_busy(evt_busy), .irq(irq)
   );

   // descriptor RAM, one cycle read latency
   logic [DW-1:0] dram [0:255];
   always @(posedge clk) begin
      if (desc_wr) dram[desc_addr] <= desc_wdata;
      if (desc_rd) desc_rdata <= dram[desc_addr];
   end

   int n_chk = 0, n_bad = 0, cycles = 0;
   bit done = 0;
   logic [DW-1:0] edesc [0:NDESC-1];
   logic [DW-1:0] snap;
   int midx = 0, mcnt = 0;
   logic movr = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] ptr_of(input int i);
      return AW'((i + 1) * 256);
   endfunction

   function automatic logic [DW-1:0] mk(input int i, input bit loop, input bit note);
      return {ptr_of(i), 16'h0, 11'h0, 1'b0, loop, note, (i == NDESC-1), 1'b1};
   endfunction

   task automatic put(input int i, input logic [DW-1:0] w);
      edesc[i] = w;
      dram[BASE + DA_W'(i)] = w;
   endtask

   task automatic rearm();
      for (int i = 0; i < NDESC; i++)
         if (!edesc[i][0] && $urandom_range(0, 1) == 1)
            put(i, mk(i, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1));
   endtask

   task automatic push(input logic [7:0] d, input bit lst, input bit er);
      logic [15:0]   s;
      logic [DW-1:0] w;
      logic [AW-1:0] ea;
      int            nidx;
      s = snap[15:0];
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = d; rx_last = lst; rx_ovr = er;
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0; rx_ovr = 1'b0;
      if (s[0]) begin
         ea = snap[32 +: AW] + AW'(mcnt);
         chk(mem_we === 1'b1 && mem_addr === ea && mem_wdata === d, "R2 byte store",
             {mem_we, mem_addr, mem_wdata}, {1'b1, ea, d});
         mcnt++;
         movr = movr | er;
         if (lst || mcnt >= int'(max_len)) begin
            w = snap;
            w[4] = movr;
            w[0] = s[3] & ~movr;
            w[31:16] = 16'(mcnt);
            nidx = s[1] ? 0 : midx + 1;
            @(negedge clk);
            chk(desc_wr === 1'b1 && desc_addr === BASE + DA_W'(midx), "R5 single write-back",
                {desc_wr, desc_addr}, {1'b1, BASE + DA_W'(midx)});
            chk(desc_wdata[31:16] === w[31:16], lst ? "R4 count at frame end" : "R3 count at max length",
                desc_wdata[31:16], w[31:16]);
            chk(desc_wdata[15:0] === w[15:0], movr ? "R7 status after overrun" : "R6 status empty bit",
                desc_wdata[15:0], w[15:0]);
            chk(desc_wdata[DW-1:16] === w[DW-1:16] && desc_wdata[3:1] === w[3:1], "R5 preserved fields",
                desc_wdata, w);
            chk(evt_rx === s[2] && irq === (s[2] & irq_mask[0]), "R9 receive event and irq",
                {evt_rx, irq}, {s[2], s[2] & irq_mask[0]});
            @(negedge clk);
            chk(desc_rd === 1'b1 && desc_addr === BASE + DA_W'(nidx), "R8/R11 next slot read",
                {desc_rd, desc_addr}, {1'b1, BASE + DA_W'(nidx)});
            @(negedge clk);
            chk(dram[BASE + DA_W'(midx)] === w, "R5 stored descriptor",
                dram[BASE + DA_W'(midx)], w);
            edesc[midx] = w;
            midx = nidx; mcnt = 0; movr = 1'b0;
            snap = edesc[midx];
         end else begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
         end
      end else begin
         chk(mem_we === 1'b0 && evt_busy === 1'b1 && irq === irq_mask[1], "R10 dropped byte and busy event",
             {mem_we, evt_busy, irq}, {1'b0, 1'b1, irq_mask[1]});
         @(negedge clk);
         chk(desc_rd === 1'b1 && desc_addr === BASE + DA_W'(midx), "R10 same slot read again",
             {desc_rd, desc_addr}, {1'b1, BASE + DA_W'(midx)});
         @(negedge clk);
         snap = edesc[midx];
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int a = 0; a < 256; a++) dram[a] = '0;
      put(0, mk(0, 1'b0, 1'b1));
      put(1, mk(1, 1'b0, 1'b0));
      put(2, mk(2, 1'b1, 1'b1));
      put(3, mk(3, 1'b1, 1'b1));
      snap = edesc[0];
      repeat (4) @(negedge clk);
      chk({mem_we, desc_wr, desc_rd, evt_rx, evt_busy, irq} === 6'b0, "R1 reset outputs",
          {mem_we, desc_wr, desc_rd, evt_rx, evt_busy, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(desc_rd === 1'b1 && desc_addr === BASE, "R1 first read at base",
          {desc_rd, desc_addr}, {1'b1, BASE});
      @(negedge clk);

      // directed: frame end close, length close, loop reuse, overrun on loop, wrap
      push(8'hA1, 0, 0); push(8'hA2, 1, 0);                         // R4
      push(8'h10, 0, 0); push(8'h11, 0, 0);
      push(8'h12, 0, 0); push(8'h13, 0, 0);                         // R3
      push(8'h20, 0, 0); push(8'h21, 0, 0); push(8'h22, 1, 0);      // R6 loop
      push(8'h30, 0, 1); push(8'h31, 1, 0);                         // R7, R8 wrap
      irq_mask = 2'b01;
      push(8'h40, 1, 0);                                            // R10 masked irq
      put(0, mk(0, 1'b0, 1'b1));
      irq_mask = 2'b10;
      push(8'h50, 1, 0);                                            // R9 masked irq
      irq_mask = 2'b11;
      put(1, mk(1, 1'b0, 1'b1));
      push(8'h60, 1, 0);                                            // R11 tight spacing
      push(8'h61, 1, 0);                                            // slot 2 loop again

      // random traffic
      for (int f = 0; f < 250; f++) begin
         int len;
         if ($urandom_range(0, 2) != 0) rearm();
         if (mcnt == 0) max_len = 16'($urandom_range(2, 8));
         irq_mask = 2'($urandom_range(0, 3));
         len = $urandom_range(1, 10);
         for (int b = 0; b < len; b++)
            push(8'($urandom), b == len - 1, $urandom_range(0, 15) == 0);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule